// File: doc/BRIEF.md
# Chipset Configuration Port Unit

This block holds the configuration state of a PC-class chipset. Software reaches it through three groups of I/O ports. The first is an index/data pair for a small bank of memory-mapper control registers. The second is an index/data pair for a 256-entry general configuration space. The third is a single system control port at 0x92.

Each mapper control register has its own write mask. Read-back merges the stored bits with bits that come from memory-size inputs. The memory mapper receives the merged view of every control register on a flat bus. The block also drives the BIOS shadow enable, the BIOS ROM decode disable, the alternate A20 gate and a one-clock soft-reset pulse.

Writes are sampled on the rising clock edge while `io_wr_i` is high, and all state changes at that edge. Read data is combinational from the address and the current state. Reads have no side effects.

Top module: `chipset_cfg_port`

## Requirements
- R1: After reset the control index is 0 and control register 0 stores 0x04. Control registers 1 to 7 store 0, except that bits 7:4 of control register 4 take `board_strap_i`. The general index, all general registers and both port 0x92 bits are 0.
- R2: Writing port 0x1ED sets the control index and writing port 0x22 sets the general index. Reading either port returns the index it holds.
- R3: Control register 0 (index 0) keeps only the written bits 4:0. Its bits 7:5 always read as `mem_cfg_hi_i`.
- R4: Control register 1 (index 1) keeps every written bit except bit 6. Bit 6 always reads as `mem_cfg_b6_i`.
- R5: A write to control register 4 (index 4) changes only bits 3:0, and bits 7:4 keep their value. `bios_off_o` equals stored bit 0 of that register.
- R6: Control register 6 (index 6) accepts a write only while control register 4 bit 7 is 1. With that bit set it reads as its stored bits 7:1 with `mem_over8m_i` in bit 0. With that bit clear it reads as 0x00.
- R7: `shadow_en_o` equals bit 4 of general register 0x82.
- R8: A write to general register 0x87 with data bit 0 set, while its stored bit 0 is 0, makes `soft_reset_o` high for exactly the one clock after the write edge. The same write with stored bit 0 already 1 gives no pulse.
- R9: Port 0x23 reads 0xFF when `cpu_alt_i` is 1 and the general index is 0x20 or at least 0xC0. Otherwise it returns the indexed register. A write to general register 0xC1 stores 0x00 unless `cpu_486_i` is 1.
- R10: Port 0x92 stores data bits 1:0. Bit 1 drives `a20_alt_o`. A write that takes bit 0 from 0 to 1 gives the same one-clock `soft_reset_o` pulse. Reads return 0xFC ORed with the stored bits.
- R11: Reads from any port other than 0x1ED, 0x1EF, 0x22, 0x23 and 0x92 return 0xFF. A control index of 8 or above reads 0xFF at port 0x1EF and ignores writes. Control register 7 ignores writes and reads 0x00.
- R12: `cr_o` byte n carries the read-back value of control register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Write strobe, sampled on the clock edge |
| io_rdata_o | output | 8 | Read data for `io_addr_i` |
| mem_cfg_hi_i | input | 3 | Memory-size bits shown in control register 0 bits 7:5 |
| mem_cfg_b6_i | input | 1 | Memory-size bit shown in control register 1 bit 6 |
| mem_over8m_i | input | 1 | Installed memory exceeds 8 MB |
| board_strap_i | input | 4 | Reset value of control register 4 bits 7:4 |
| cpu_alt_i | input | 1 | CPU-type strap that hides part of the general space |
| cpu_486_i | input | 1 | 486 strap that allows writes to general register 0xC1 |
| soft_reset_o | output | 1 | One-clock soft-reset pulse |
| a20_alt_o | output | 1 | Alternate A20 gate |
| shadow_en_o | output | 1 | BIOS shadow read enable, BIOS write block |
| bios_off_o | output | 1 | BIOS ROM decode disable |
| cr_o | output | NUM_CR*8 (64) | Merged view of all control registers |

## Verification
A write that lands under the wrong mask or in the wrong index shows up on `cr_o` and on the status outputs at the negative edge after the write edge. The bench compares them after every write, so a fault is seen within one clock. An edge detector that compares against the new value instead of the old one shows up on `soft_reset_o` in that same cycle: the pulse either disappears or repeats. Overlay and hiding faults are combinational, so the next read through the data ports exposes them at once.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  typedef logic [7:0] byte_t;

  localparam logic [15:0] PORT_CR_IDX = 16'h01ED;
  localparam logic [15:0] PORT_CR_DAT = 16'h01EF;
  localparam logic [15:0] PORT_AX_IDX = 16'h0022;
  localparam logic [15:0] PORT_AX_DAT = 16'h0023;
  localparam logic [15:0] PORT_SYS    = 16'h0092;

  localparam byte_t CR_MAP0  = 8'd0;
  localparam byte_t CR_MAP1  = 8'd1;
  localparam byte_t CR_ROM   = 8'd4;
  localparam byte_t CR_EXT   = 8'd6;
  localparam byte_t CR_RO    = 8'd7;
  localparam byte_t CR0_RST  = 8'h04;

  localparam byte_t AX_SHADOW = 8'h82;
  localparam byte_t AX_RESET  = 8'h87;
  localparam byte_t AX_GATED  = 8'hC1;
  localparam byte_t AX_HOLE   = 8'h20;
  localparam byte_t AX_HI     = 8'hC0;
endpackage

// File: rtl/cfg_cr_bank.sv
`timescale 1ns/1ps
module cfg_cr_bank
  import cfgp_pkg::*;
#(
  parameter int NUM_CR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic              dat_we_i,
  input  byte_t             wdata_i,
  input  logic [2:0]        mem_cfg_hi_i,
  input  logic              mem_cfg_b6_i,
  input  logic              mem_over8m_i,
  input  logic [3:0]        strap_i,
  output byte_t             idx_o,
  output byte_t             rdata_o,
  output logic              bios_off_o,
  output logic [NUM_CR*8-1:0] cr_o
);
  localparam int    SW    = $clog2(NUM_CR);
  localparam byte_t LIMIT = byte_t'(NUM_CR);

  byte_t idx_q;
  byte_t cr_q [NUM_CR];
  byte_t view [NUM_CR];
  logic  in_range;

  assign in_range = idx_q < LIMIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < NUM_CR; i++) cr_q[i] <= '0;
      cr_q[CR_MAP0[SW-1:0]] <= CR0_RST;
      cr_q[CR_ROM[SW-1:0]]  <= {strap_i, 4'h0};
    end else begin
      if (idx_we_i) idx_q <= wdata_i;
      if (dat_we_i && in_range) begin
        case (idx_q)
          CR_MAP0: cr_q[CR_MAP0[SW-1:0]] <= {3'b000, wdata_i[4:0]};
          CR_MAP1: cr_q[CR_MAP1[SW-1:0]] <= wdata_i & 8'hBF;
          CR_ROM:  cr_q[CR_ROM[SW-1:0]][3:0] <= wdata_i[3:0];
          CR_EXT:  if (cr_q[CR_ROM[SW-1:0]][7]) cr_q[CR_EXT[SW-1:0]] <= {wdata_i[7:1], 1'b0};
          CR_RO:   ;
          default: cr_q[idx_q[SW-1:0]] <= wdata_i;
        endcase
      end
    end
  end

  // stored bits merged with the memory-size overlays
  always_comb begin
    for (int i = 0; i < NUM_CR; i++) view[i] = cr_q[i];
    view[CR_MAP0[SW-1:0]][7:5] = mem_cfg_hi_i;
    view[CR_MAP1[SW-1:0]][6]   = mem_cfg_b6_i;
    view[CR_EXT[SW-1:0]] = cr_q[CR_ROM[SW-1:0]][7]
                         ? {cr_q[CR_EXT[SW-1:0]][7:1], mem_over8m_i} : 8'h00;
  end

  for (genvar g = 0; g < NUM_CR; g++) begin : g_out
    assign cr_o[g*8 +: 8] = view[g];
  end

  assign rdata_o    = in_range ? view[idx_q[SW-1:0]] : 8'hFF;
  assign idx_o      = idx_q;
  assign bios_off_o = cr_q[CR_ROM[SW-1:0]][0];
endmodule

// File: rtl/cfg_aux_bank.sv
`timescale 1ns/1ps
module cfg_aux_bank
  import cfgp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  idx_we_i,
  input  logic  dat_we_i,
  input  byte_t wdata_i,
  input  logic  cpu_alt_i,
  input  logic  cpu_486_i,
  output byte_t idx_o,
  output byte_t rdata_o,
  output logic  shadow_o,
  output logic  rst_req_o
);
  localparam int DEPTH = 256;

  byte_t idx_q;
  byte_t ax_q [DEPTH];
  logic  hidden;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) ax_q[i] <= '0;
    end else begin
      if (idx_we_i) idx_q <= wdata_i;
      if (dat_we_i) ax_q[idx_q] <= (idx_q == AX_GATED && !cpu_486_i) ? 8'h00 : wdata_i;
    end
  end

  assign hidden    = cpu_alt_i && (idx_q == AX_HOLE || idx_q >= AX_HI);
  assign rdata_o   = hidden ? 8'hFF : ax_q[idx_q];
  assign idx_o     = idx_q;
  assign shadow_o  = ax_q[AX_SHADOW][4];
  // edge compares against the value held before this write
  assign rst_req_o = dat_we_i && idx_q == AX_RESET && wdata_i[0] && !ax_q[AX_RESET][0];
endmodule

// File: rtl/cfg_sys_port.sv
`timescale 1ns/1ps
module cfg_sys_port
  import cfgp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wbits_i,
  output byte_t      rdata_o,
  output logic       a20_o,
  output logic       rst_req_o
);
  logic [1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bits_q <= '0;
    else if (we_i) bits_q <= wbits_i;
  end

  assign rdata_o   = {6'h3F, bits_q};
  assign a20_o     = bits_q[1];
  assign rst_req_o = we_i && wbits_i[0] && !bits_q[0];
endmodule

// File: rtl/chipset_cfg_port.sv
`timescale 1ns/1ps
module chipset_cfg_port
  import cfgp_pkg::*;
#(
  parameter int NUM_CR = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [15:0]         io_addr_i,
  input  logic [7:0]          io_wdata_i,
  input  logic                io_wr_i,
  output logic [7:0]          io_rdata_o,
  input  logic [2:0]          mem_cfg_hi_i,
  input  logic                mem_cfg_b6_i,
  input  logic                mem_over8m_i,
  input  logic [3:0]          board_strap_i,
  input  logic                cpu_alt_i,
  input  logic                cpu_486_i,
  output logic                soft_reset_o,
  output logic                a20_alt_o,
  output logic                shadow_en_o,
  output logic                bios_off_o,
  output logic [NUM_CR*8-1:0] cr_o
);
  byte_t cr_idx, cr_rd, ax_idx, ax_rd, sys_rd;
  logic  ax_rst, sys_rst, soft_q;

  cfg_cr_bank #(.NUM_CR(NUM_CR)) i_cr (
    .clk_i, .rst_ni,
    .idx_we_i    (io_wr_i && io_addr_i == PORT_CR_IDX),
    .dat_we_i    (io_wr_i && io_addr_i == PORT_CR_DAT),
    .wdata_i     (io_wdata_i),
    .mem_cfg_hi_i, .mem_cfg_b6_i, .mem_over8m_i,
    .strap_i     (board_strap_i),
    .idx_o       (cr_idx),
    .rdata_o     (cr_rd),
    .bios_off_o,
    .cr_o
  );

  cfg_aux_bank i_aux (
    .clk_i, .rst_ni,
    .idx_we_i  (io_wr_i && io_addr_i == PORT_AX_IDX),
    .dat_we_i  (io_wr_i && io_addr_i == PORT_AX_DAT),
    .wdata_i   (io_wdata_i),
    .cpu_alt_i, .cpu_486_i,
    .idx_o     (ax_idx),
    .rdata_o   (ax_rd),
    .shadow_o  (shadow_en_o),
    .rst_req_o (ax_rst)
  );

  cfg_sys_port i_sys (
    .clk_i, .rst_ni,
    .we_i      (io_wr_i && io_addr_i == PORT_SYS),
    .wbits_i   (io_wdata_i[1:0]),
    .rdata_o   (sys_rd),
    .a20_o     (a20_alt_o),
    .rst_req_o (sys_rst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_q <= 1'b0;
    else         soft_q <= ax_rst | sys_rst;
  end
  assign soft_reset_o = soft_q;

  always_comb begin
    case (io_addr_i)
      PORT_CR_IDX: io_rdata_o = cr_idx;
      PORT_CR_DAT: io_rdata_o = cr_rd;
      PORT_AX_IDX: io_rdata_o = ax_idx;
      PORT_AX_DAT: io_rdata_o = ax_rd;
      PORT_SYS:    io_rdata_o = sys_rd;
      default:     io_rdata_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/chipset_cfg_port_chk.sv
`timescale 1ns/1ps
module chipset_cfg_port_chk #(
  parameter int NUM_CR = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [15:0]         io_addr_i,
  input logic                io_wr_i,
  input logic [7:0]          io_rdata_o,
  input logic [2:0]          mem_cfg_hi_i,
  input logic                soft_reset_o,
  input logic                a20_alt_o,
  input logic                bios_off_o,
  input logic [NUM_CR*8-1:0] cr_o
);
  // R8
  pulse_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_reset_o |-> $past(io_wr_i));
  // R10
  sys_read_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i == 16'h0092) |-> (io_rdata_o[7:2] == 6'h3F));
  // R10
  a20_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(a20_alt_o) |-> $past(io_wr_i && io_addr_i == 16'h0092));
  // R5
  bios_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bios_off_o) |-> $past(io_wr_i && io_addr_i == 16'h01EF));
  // R3
  cr0_overlay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_o[7:5] == mem_cfg_hi_i);
  // R6
  cr6_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_o[39] |-> (cr_o[55:48] == 8'h00));
  // R11
  unassigned_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i != 16'h01ED && io_addr_i != 16'h01EF && io_addr_i != 16'h0022 &&
     io_addr_i != 16'h0023 && io_addr_i != 16'h0092) |-> (io_rdata_o == 8'hFF));
endmodule

bind chipset_cfg_port chipset_cfg_port_chk #(.NUM_CR(NUM_CR)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .io_wr_i(io_wr_i),
  .io_rdata_o(io_rdata_o), .mem_cfg_hi_i(mem_cfg_hi_i), .soft_reset_o(soft_reset_o),
  .a20_alt_o(a20_alt_o), .bios_off_o(bios_off_o), .cr_o(cr_o)
);

// File: tb/test_chipset_cfg_port.sv
`timescale 1ns/1ps
module test_chipset_cfg_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic [2:0]  mem_hi = 3'b101;
  logic        mem_b6 = 1'b0;
  logic        big = 1'b0;
  logic [3:0]  strap = 4'h2;
  logic        cpu_alt = 1'b0;
  logic        cpu_486 = 1'b0;
  logic        soft_rst, a20, shadow, bios_off;
  logic [63:0] cr;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [7:0] m_cr [8];
  logic [7:0] m_cri;
  logic [7:0] m_aux [256];
  logic [7:0] m_axi;
  logic [1:0] m_p92;
  logic       m_pulse;

  always #2.5 clk = ~clk;

  chipset_cfg_port i_chipset_cfg_port (
    .clk_i(clk), .rst_ni(rst_ni), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_wr_i(io_wr), .io_rdata_o(io_rdata), .mem_cfg_hi_i(mem_hi), .mem_cfg_b6_i(mem_b6),
    .mem_over8m_i(big), .board_strap_i(strap), .cpu_alt_i(cpu_alt), .cpu_486_i(cpu_486),
    .soft_reset_o(soft_rst), .a20_alt_o(a20), .shadow_en_o(shadow), .bios_off_o(bios_off),
    .cr_o(cr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdl_reset();
    for (int i = 0; i < 8; i++) m_cr[i] = 8'h00;
    m_cr[0] = 8'h04;
    m_cr[4] = {strap, 4'h0};
    for (int i = 0; i < 256; i++) m_aux[i] = 8'h00;
    m_cri = 8'h00; m_axi = 8'h00; m_p92 = 2'b00;
  endtask

  function automatic logic [7:0] mdl_view(input int i);
    case (i)
      0: return {mem_hi, m_cr[0][4:0]};
      1: return {m_cr[1][7], mem_b6, m_cr[1][5:0]};
      6: return m_cr[4][7] ? {m_cr[6][7:1], big} : 8'h00;
      default: return m_cr[i];
    endcase
  endfunction

  function automatic logic [63:0] mdl_cr_all();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mdl_view(i);
    return v;
  endfunction

  function automatic logic [7:0] mdl_rd(input logic [15:0] a);
    case (a)
      16'h01ED: return m_cri;
      16'h01EF: return (m_cri >= 8) ? 8'hFF : mdl_view(int'(m_cri));
      16'h0022: return m_axi;
      16'h0023: return (cpu_alt && (m_axi == 8'h20 || m_axi >= 8'hC0)) ? 8'hFF : m_aux[m_axi];
      16'h0092: return {6'h3F, m_p92};
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic mdl_wr(input logic [15:0] a, input logic [7:0] d);
    m_pulse = 1'b0;
    case (a)
      16'h01ED: m_cri = d;
      16'h01EF: case (m_cri)
        8'd0: m_cr[0] = {3'b000, d[4:0]};
        8'd1: m_cr[1] = d & 8'hBF;
        8'd4: m_cr[4] = {m_cr[4][7:4], d[3:0]};
        8'd6: if (m_cr[4][7]) m_cr[6] = {d[7:1], 1'b0};
        8'd2, 8'd3, 8'd5: m_cr[m_cri[2:0]] = d;
        default: ;
      endcase
      16'h0022: m_axi = d;
      16'h0023: begin
        if (m_axi == 8'h87 && d[0] && !m_aux[8'h87][0]) m_pulse = 1'b1;
        m_aux[m_axi] = (m_axi == 8'hC1 && !cpu_486) ? 8'h00 : d;
      end
      16'h0092: begin
        if (d[0] && !m_p92[0]) m_pulse = 1'b1;
        m_p92 = d[1:0];
      end
      default: ;
    endcase
  endtask

  // write one cycle, then compare the state visible at the ports
  task automatic do_wr(input string req, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    mdl_wr(a, d);
    @(negedge clk);
    io_wr = 1'b0;
    check({req, " soft_reset"}, 64'(soft_rst), 64'(m_pulse));
    check({req, " cr_o (R12)"}, cr, mdl_cr_all());
    check({req, " a20 (R10)"}, 64'(a20), 64'(m_p92[1]));
    check({req, " shadow (R7)"}, 64'(shadow), 64'(m_aux[8'h82][4]));
    check({req, " bios_off (R5)"}, 64'(bios_off), 64'(m_cr[4][0]));
  endtask

  task automatic do_rd(input string req, input logic [15:0] a);
    @(negedge clk);
    io_addr = a;
    #1;
    check(req, 64'(io_rdata), 64'(mdl_rd(a)));
  endtask

  task automatic expect_rd(input string req, input logic [15:0] a, input logic [7:0] e);
    @(negedge clk);
    io_addr = a;
    #1;
    check(req, 64'(io_rdata), 64'(e));
  endtask

  task automatic apply_reset(input logic [3:0] s);
    @(negedge clk);
    strap = s; rst_ni = 1'b0;
    mdl_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] ports [7];
    logic [7:0]  idxs [8];
    int unsigned seed;
    ports = '{16'h01ED, 16'h01EF, 16'h0022, 16'h0023, 16'h0092, 16'h01EE, 16'h0060};
    idxs  = '{8'h20, 8'h82, 8'h87, 8'hC0, 8'hC1, 8'h55, 8'hFE, 8'h00};
    seed = 32'd4242;
    void'($urandom(seed));

    // phase A: strap leaves register 4 bit 7 clear
    apply_reset(4'h2);
    @(negedge clk);
    // R1 reset state
    check("R1 cr_o after reset", cr, {8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, {3'b101, 5'h04}});
    check("R1 soft_reset idle", 64'(soft_rst), 64'd0);
    expect_rd("R1 control index", 16'h01ED, 8'h00);
    expect_rd("R1 port 0x92", 16'h0092, 8'hFC);
    // R2
    do_wr("R2", 16'h01ED, 8'h00);
    do_wr("R3 write ff", 16'h01EF, 8'hFF);
    expect_rd("R3 readback", 16'h01EF, {3'b101, 5'h1F});
    do_wr("R2", 16'h01ED, 8'h01);
    expect_rd("R2 index readback", 16'h01ED, 8'h01);
    do_wr("R4 write ff", 16'h01EF, 8'hFF);
    expect_rd("R4 bit6 low", 16'h01EF, 8'hBF);
    mem_b6 = 1'b1;
    expect_rd("R4 bit6 high", 16'h01EF, 8'hFF);
    do_wr("R2", 16'h01ED, 8'h04);
    do_wr("R5 write ff", 16'h01EF, 8'hFF);
    expect_rd("R5 upper nibble kept", 16'h01EF, 8'h2F);
    check("R5 bios_off set", 64'(bios_off), 64'd1);
    do_wr("R5 write 0", 16'h01EF, 8'h00);
    check("R5 bios_off clear", 64'(bios_off), 64'd0);
    do_wr("R2", 16'h01ED, 8'h06);
    do_wr("R6 gated write", 16'h01EF, 8'hFF);
    expect_rd("R6 reads zero when gated", 16'h01EF, 8'h00);
    do_wr("R2", 16'h01ED, 8'h07);
    do_wr("R11 reg7 write", 16'h01EF, 8'h55);
    expect_rd("R11 reg7 reads zero", 16'h01EF, 8'h00);
    do_wr("R2", 16'h01ED, 8'h09);
    do_wr("R11 out of range write", 16'h01EF, 8'h55);
    expect_rd("R11 out of range read", 16'h01EF, 8'hFF);
    expect_rd("R11 unassigned port", 16'h0060, 8'hFF);
    // general space
    do_wr("R2", 16'h0022, 8'h82);
    expect_rd("R2 general index", 16'h0022, 8'h82);
    do_wr("R7 shadow on", 16'h0023, 8'h10);
    check("R7 shadow set", 64'(shadow), 64'd1);
    do_wr("R2", 16'h0022, 8'h87);
    do_wr("R8 rising", 16'h0023, 8'h01);
    @(negedge clk);
    check("R8 pulse one clock", 64'(soft_rst), 64'd0);
    do_wr("R8 already set", 16'h0023, 8'h01);
    do_wr("R8 clear", 16'h0023, 8'h00);
    do_wr("R8 rising again", 16'h0023, 8'h01);
    do_wr("R2", 16'h0022, 8'hC1);
    cpu_486 = 1'b0;
    do_wr("R9 gated c1", 16'h0023, 8'hAA);
    expect_rd("R9 c1 forced zero", 16'h0023, 8'h00);
    cpu_486 = 1'b1;
    do_wr("R9 open c1", 16'h0023, 8'hAA);
    expect_rd("R9 c1 written", 16'h0023, 8'hAA);
    cpu_alt = 1'b1;
    expect_rd("R9 hidden high index", 16'h0023, 8'hFF);
    do_wr("R2", 16'h0022, 8'h20);
    expect_rd("R9 hidden 0x20", 16'h0023, 8'hFF);
    cpu_alt = 1'b0;
    expect_rd("R9 visible 0x20", 16'h0023, 8'h00);
    do_wr("R10 a20", 16'h0092, 8'h02);
    expect_rd("R10 read pad", 16'h0092, 8'hFE);
    do_wr("R10 rising bit0", 16'h0092, 8'h03);
    do_wr("R10 bit0 held", 16'h0092, 8'hFD);

    // phase B: strap sets register 4 bit 7
    apply_reset(4'hA);
    @(negedge clk);
    check("R1 strap in cr4", 64'(cr[39:32]), 64'hA0);
    do_wr("R2", 16'h01ED, 8'h06);
    big = 1'b1;
    do_wr("R6 open write", 16'h01EF, 8'hFF);
    expect_rd("R6 readback over8m", 16'h01EF, 8'hFF);
    big = 1'b0;
    expect_rd("R6 readback under8m", 16'h01EF, 8'hFE);

    // constrained random against the reference state
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      @(negedge clk);
      mem_hi  = 3'($urandom_range(0, 7));
      mem_b6  = 1'($urandom_range(0, 1));
      big     = 1'($urandom_range(0, 1));
      cpu_alt = 1'($urandom_range(0, 1));
      cpu_486 = 1'($urandom_range(0, 1));
      a = ports[$urandom_range(0, 6)];
      d = 8'($urandom_range(0, 255));
      if (a == 16'h01ED) d = 8'($urandom_range(0, 9));
      if (a == 16'h0022) d = idxs[$urandom_range(0, 7)];
      if ($urandom_range(0, 2) == 0) do_rd("R12 random read", a);
      else                           do_wr("R12 random write", a, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule